// File: doc/BRIEF.md
# Seconds Counter with Compare Interrupt

This block is a bus-accessible real-time clock. A counter of seconds advances by one on every cycle in which the one-second enable input is high. Software can load the counter with any value, and from then on the counter continues to count up from that value. A compare register holds an alarm value. When a tick brings the counter to that value, a sticky raw interrupt flag is set. A one-bit mask gates the flag onto the interrupt output. Software drops the flag by writing the clear register.

Access goes through a plain register port. It has write and read enables, a word index, 32-bit write data and registered read data. An error strobe pulses when software writes to a read-only or unmapped location. Writes to the control location are accepted and do nothing. The clock divider that produces the tick, calendar conversion and state save or restore all live outside this block.

Top module: `rtc_match_top`

## Requirements
- R1: After reset the count, compare value, mask bit and raw flag are all zero. `irq` and `err` are low, and `rdata` reads zero.
- R2: In a cycle with `sec_tick` high and no load write, the count rises by one on the next edge, wrapping from all ones to zero. Without a tick and without a load, the count holds.
- R3: A write to word index 2 (load) puts `wdata` into the count on that edge. The count then keeps advancing from that value. A load takes priority over a tick in the same cycle, and that tick is lost.
- R4: A write to word index 1 (compare) stores all of `wdata`. Reads of index 1 return the stored value.
- R5: On a tick that is not overridden by a load, the raw flag sets if the incremented count equals the compare value held before that edge. Once set, the flag stays set while the count moves on, until a clear write.
- R6: A write to word index 7 (clear), with any data including zero, drops the raw flag. If a compare hit happens in the same cycle, the flag stays set.
- R7: A write to word index 4 (mask) keeps only `wdata[0]`. `irq`, and reads of index 6 (masked status), equal raw flag AND mask. The change is visible in the cycle after the write edge.
- R8: A write to word index 3 (control) changes no state and raises no error. Index 3 and index 7 read as zero.
- R9: A write to index 0 (count), index 5 (raw status) or index 6 (masked status) pulses `err` for exactly the cycle after the write edge, and changes no state.
- R10: A write to any index from 8 to 15 pulses `err` the same way. Reads of those indices return zero and never raise `err`.
- R11: A read with `rd_en` returns its value on `rdata` in the cycle after the edge, using the state from before that edge. Index 0 and index 2 return the count, index 4 returns the mask in bit 0, and index 5 returns the raw flag in bit 0. `rdata` holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| sec_tick | input | 1 | One-cycle enable, once per second |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle pulse after a refused write |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong count shows up on the very next read of index 0. If the count runs one tick ahead or behind, the alarm also fires on the wrong tick, and `irq` rises one cycle away from the edge the model predicts. A compare or mask register that is corrupted, for example by a write to a read-only location, shows on the next read and shifts or suppresses the following alarm. A raw flag that stays set or clears at the wrong time shows directly on `irq` in the cycle after the offending edge, as long as the mask is set. The random phase keeps loads and compare values close together so that alarms, clears and collisions happen often.

// File: rtl/rtc_match_pkg.sv
package rtc_match_pkg;
  // word indices of the register map
  localparam int unsigned IDX_COUNT  = 0;
  localparam int unsigned IDX_CMP    = 1;
  localparam int unsigned IDX_LOAD   = 2;
  localparam int unsigned IDX_CTRL   = 3;
  localparam int unsigned IDX_MASK   = 4;
  localparam int unsigned IDX_RAW    = 5;
  localparam int unsigned IDX_MSKD   = 6;
  localparam int unsigned IDX_CLEAR  = 7;
  localparam int unsigned NUM_MAPPED = 8;

  typedef struct packed {
    logic load;
    logic cmp;
    logic mask;
    logic clear;
    logic bad;
  } wr_dec_t;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // a load wins over a tick in the same cycle
  always_comb begin
    adv_o  = tick_i & ~load_i;
    cnt_en = tick_i | load_i;
    cnt_d  = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (tick_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clear_i,
  output logic             raw_o
);
  logic raw_q;
  logic raw_d;
  logic hit;
  logic raw_en;

  // the compare looks at the value the counter takes on this edge
  always_comb begin
    hit    = adv_i && ((cnt_i + CNT_W'(1)) == cmp_i);
    raw_en = hit | clear_i;
    raw_d  = raw_q;
    if (hit)          raw_d = 1'b1;
    else if (clear_i) raw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= 1'b0;
    else if (raw_en) raw_q <= raw_d;
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_match_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              raw_i,
  output wr_dec_t           dec_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              mask_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  localparam int unsigned PAD_W = DATA_W - 1;

  logic [CNT_W-1:0]  cmp_q,   cmp_d;
  logic              mask_q,  mask_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q;
  logic [DATA_W-1:0] rd_val;
  wr_dec_t           dec;

  // write decode
  always_comb begin
    dec = '0;
    if (wr_en) begin
      if (addr >= ADDR_W'(NUM_MAPPED)) begin
        dec.bad = 1'b1;
      end else begin
        case (addr)
          ADDR_W'(IDX_LOAD):  dec.load  = 1'b1;
          ADDR_W'(IDX_CMP):   dec.cmp   = 1'b1;
          ADDR_W'(IDX_MASK):  dec.mask  = 1'b1;
          ADDR_W'(IDX_CLEAR): dec.clear = 1'b1;
          ADDR_W'(IDX_COUNT),
          ADDR_W'(IDX_RAW),
          ADDR_W'(IDX_MSKD):  dec.bad   = 1'b1;
          default:            dec       = '0;
        endcase
      end
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    case (addr)
      ADDR_W'(IDX_COUNT),
      ADDR_W'(IDX_LOAD): rd_val = DATA_W'(cnt_i);
      ADDR_W'(IDX_CMP):  rd_val = DATA_W'(cmp_q);
      ADDR_W'(IDX_MASK): rd_val = {{PAD_W{1'b0}}, mask_q};
      ADDR_W'(IDX_RAW):  rd_val = {{PAD_W{1'b0}}, raw_i};
      ADDR_W'(IDX_MSKD): rd_val = {{PAD_W{1'b0}}, raw_i & mask_q};
      default:           rd_val = '0;
    endcase
  end

  // next state
  always_comb begin
    cmp_d   = dec.cmp  ? wdata[CNT_W-1:0] : cmp_q;
    mask_d  = dec.mask ? wdata[0]         : mask_q;
    rdata_d = rd_en    ? rd_val           : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      mask_q  <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (dec.cmp)  cmp_q   <= cmp_d;
      if (dec.mask) mask_q  <= mask_d;
      if (rd_en)    rdata_q <= rdata_d;
      err_q <= dec.bad;
    end
  end

  assign dec_o   = dec;
  assign cmp_o   = cmp_q;
  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/rtc_match_top.sv
module rtc_match_top
  import rtc_match_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              irq
);
  wr_dec_t          dec_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] cmp_w;
  logic             adv_w;
  logic             raw_w;
  logic             mask_w;

  rtc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .cnt_i   (cnt_w),
    .raw_i   (raw_w),
    .dec_o   (dec_w),
    .cmp_o   (cmp_w),
    .mask_o  (mask_w),
    .rdata_o (rdata),
    .err_o   (err)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (sec_tick),
    .load_i     (dec_w.load),
    .load_val_i (wdata[CNT_W-1:0]),
    .cnt_o      (cnt_w),
    .adv_o      (adv_w)
  );

  rtc_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (adv_w),
    .cnt_i   (cnt_w),
    .cmp_i   (cmp_w),
    .clear_i (dec_w.clear),
    .raw_o   (raw_w)
  );

  assign irq = raw_w & mask_w;
endmodule

// File: rtl/rtc_match_chk.sv
module rtc_match_chk
  import rtc_match_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              err,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cmp_q,
  input logic              raw_q
);
  logic wr_load, wr_clear, wr_ro, wr_ctrl, wr_mask0;
  assign wr_load  = wr_en && (addr == ADDR_W'(IDX_LOAD));
  assign wr_clear = wr_en && (addr == ADDR_W'(IDX_CLEAR));
  assign wr_ctrl  = wr_en && (addr == ADDR_W'(IDX_CTRL));
  assign wr_mask0 = wr_en && (addr == ADDR_W'(IDX_MASK)) && !wdata[0];
  assign wr_ro    = wr_en && ((addr == ADDR_W'(IDX_COUNT)) ||
                              (addr == ADDR_W'(IDX_RAW))   ||
                              (addr == ADDR_W'(IDX_MSKD)));

  assert_load_sets_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> cnt_q == $past(wdata[CNT_W-1:0]));

  assert_tick_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !wr_load) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !wr_load) |=> $stable(cnt_q));

  assert_raw_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !wr_clear) |=> raw_q);

  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clear && !(sec_tick && !wr_load && (cnt_q + CNT_W'(1) == cmp_q))) |=> !raw_q);

  assert_mask_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask0 |=> !irq);

  assert_ro_write_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ro |=> (err && $stable(cmp_q)));

  assert_ctrl_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (!err && $stable(cmp_q)));
endmodule

bind rtc_match_top rtc_match_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sec_tick (sec_tick),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .err      (err),
  .irq      (irq),
  .cnt_q    (cnt_w),
  .cmp_q    (cmp_w),
  .raw_q    (raw_w)
);

// File: tb/tb_rtc_match_top.sv
module tb_rtc_match_top;
  logic        clk;
  logic        rst_n;
  logic        sec_tick;
  logic        wr_en;
  logic        rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        err;
  logic        irq;

  int unsigned n_chk;
  int unsigned n_bad;
  bit          done;

  // bench model state
  logic [31:0] m_cnt, m_cmp;
  logic        m_mask, m_raw;

  rtc_match_top dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .err(err), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0, 4'd2: return m_cnt;
      4'd1:       return m_cmp;
      4'd4:       return {31'b0, m_mask};
      4'd5:       return {31'b0, m_raw};
      4'd6:       return {31'b0, m_raw & m_mask};
      default:    return 32'h0;
    endcase
  endfunction

  function automatic bit exp_err(input bit we, input logic [3:0] a);
    return we && (a == 4'd0 || a == 4'd5 || a == 4'd6 || a >= 4'd8);
  endfunction

  // one bus cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit we, input bit re, input logic [3:0] a,
                      input logic [31:0] wd, input bit tk, input string tag);
    logic [31:0] e_rd;
    bit          e_err;
    bit          ld, hit;
    sec_tick = tk; wr_en = we; rd_en = re; addr = a; wdata = wd;
    @(posedge clk);
    e_rd  = exp_read(a);
    e_err = exp_err(we, a);
    ld    = we && a == 4'd2;
    hit   = tk && !ld && (m_cnt + 32'd1 == m_cmp);
    if (hit)                 m_raw = 1'b1;
    else if (we && a == 4'd7) m_raw = 1'b0;
    if (ld)      m_cnt = wd;
    else if (tk) m_cnt = m_cnt + 32'd1;
    if (we && a == 4'd1) m_cmp  = wd;
    if (we && a == 4'd4) m_mask = wd[0];
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    chk(irq == (m_raw & m_mask), tag, "irq", {31'b0, irq}, {31'b0, m_raw & m_mask});
    chk(err == e_err, tag, "err", {31'b0, err}, {31'b0, e_err});
    if (re) chk(rdata == e_rd, tag, $sformatf("rdata idx %0d", a), rdata, e_rd);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(1'b0, 1'b1, a, 32'h0, 1'b0, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, a, d, 1'b0, tag);
  endtask

  task automatic tick(input string tag);
    step(1'b0, 1'b0, 4'd0, 32'h0, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    m_cnt = '0; m_cmp = '0; m_mask = 1'b0; m_raw = 1'b0;
    sec_tick = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(irq == 1'b0 && err == 1'b0, "R1", "irq/err after reset", {30'b0, irq, err}, 32'h0);
    chk(rdata == 32'h0, "R1", "rdata after reset", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) rd(4'(i), "R1");

    // R2: advance, hold, wrap
    tick("R2"); tick("R2"); rd(4'd0, "R2");
    rd(4'd0, "R2");
    wr(4'd2, 32'hFFFF_FFFF, "R3"); tick("R2"); rd(4'd0, "R2");
    // R3: load then advance, load beats tick
    wr(4'd2, 32'h0000_1000, "R3"); tick("R3"); rd(4'd2, "R3");
    step(1'b1, 1'b0, 4'd2, 32'h0000_5000, 1'b1, "R3"); rd(4'd0, "R3");
    // R4: compare store
    wr(4'd1, 32'hA5A5_0003, "R4"); rd(4'd1, "R4");
    // R5/R7: alarm with mask
    wr(4'd4, 32'hFFFF_FFFE, "R7"); rd(4'd4, "R7");
    wr(4'd2, 32'hA5A5_0001, "R5"); tick("R5"); rd(4'd5, "R5");
    tick("R5"); rd(4'd5, "R5"); tick("R5"); rd(4'd5, "R5");
    rd(4'd6, "R7");
    wr(4'd4, 32'h0000_0001, "R7"); rd(4'd6, "R7");
    // R6: clear with zero data
    wr(4'd7, 32'h0, "R6"); rd(4'd5, "R6");
    // R6: clear collides with hit
    wr(4'd2, 32'hA5A5_0002, "R6");
    step(1'b1, 1'b0, 4'd7, 32'h0, 1'b1, "R6"); rd(4'd5, "R6");
    // R5: load lands on compare value, no tick -> no alarm
    wr(4'd7, 32'h1, "R6"); wr(4'd2, 32'hA5A5_0003, "R5"); rd(4'd5, "R5");
    // R8: control write
    wr(4'd3, 32'hFFFF_FFFF, "R8"); rd(4'd3, "R8"); rd(4'd1, "R8"); rd(4'd7, "R8");
    // R9: read-only writes
    wr(4'd0, 32'h1234_5678, "R9"); rd(4'd0, "R9");
    wr(4'd5, 32'h0, "R9"); rd(4'd5, "R9");
    wr(4'd6, 32'h0, "R9"); rd(4'd1, "R9");
    // R10: unmapped
    wr(4'd9, 32'hDEAD_BEEF, "R10"); wr(4'd15, 32'h1, "R10"); rd(4'd12, "R10");
    // R11: read and write same cycle returns old state
    step(1'b1, 1'b1, 4'd1, 32'h7777_0000, 1'b0, "R11"); rd(4'd1, "R11");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0]  a;
      logic [31:0] d;
      bit          we, re, tk;
      a  = 4'($urandom_range(0, 15));
      we = ($urandom_range(0, 1) == 1);
      re = ($urandom_range(0, 1) == 1);
      tk = ($urandom_range(0, 9) < 4);
      d  = $urandom();
      if (a == 4'd2 && $urandom_range(0, 9) < 6) d = m_cmp - 32'($urandom_range(1, 4));
      if (a == 4'd1 && $urandom_range(0, 9) < 6) d = m_cnt + 32'($urandom_range(1, 4));
      step(we, re, a, d, tk, "R11");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule